// File: doc/BRIEF.md
# Machine-Cycle Bus Sequencer

This block drives the external bus of an 8-bit processor one machine cycle at a time. Each machine cycle is a run of clock-period states T1..Tn. Every state is split into a first half and a second half, and each half lasts one clock of `clk`, so the strobes can change in the middle of a state. The cycle type and its base length come in on a request port. The sequencer captures that request on the final clock of the cycle before it. It then steps through the states, inserts automatic and external wait states after T2, and drives the memory-request, I/O-request, read, write and opcode-fetch strobes.

A controller upstream supplies the sequence of machine cycles that makes up an instruction: an opcode fetch first, then data reads and writes to memory or I/O. Interrupt acknowledge is sequenced as a bus cycle of its own. The sequencer reports which machine cycle of the instruction is active, which state within it is active, and whether a wait state is in progress. A one-clock done pulse marks the moment it accepts the next request.

Top module: `mcycle_sequencer`

## Requirements
- R1: While `rst_n` is low, the block is in the first half of T1 of an opcode fetch of base length 4, with `m_idx`=1, `t_idx`=1, `in_wait`=0, `cyc_done`=0, `m1`=1 and `mreq`, `iorq`, `rd`, `wr` all 0.
- R2: Each state lasts two clocks: a first half, then a second half. A cycle runs T1..Tn, where n is the captured base length. `req_type` encodes 0=opcode fetch, 1=memory read, 2=memory write, 3=I/O read, 4=I/O write, 5=interrupt acknowledge. For fetch and acknowledge, n is `req_len` clamped to 4..6. For the other types it is clamped to 3..5.
- R3: `wait_req` is sampled only in the second half of T2, or of the last wait state that follows T2 once the automatic waits are used up. When it is high, one more wait state follows, shown as `t_idx`=2 with `in_wait`=1. At every other clock its value has no effect.
- R4: I/O read and I/O write cycles insert one automatic wait state after T2. Interrupt acknowledge inserts two. These come before `wait_req` is first sampled.
- R5: `cyc_done` is high for exactly the one clock that forms the second half of Tn. The request inputs are captured on that clock edge and ignored at all other times. The next clock is the first half of T1 of the new cycle.
- R6: On capture, `m_idx` becomes 1 for an opcode fetch or interrupt acknowledge. For any other type it becomes the previous value plus one, held at 7 once it reaches 7.
- R7: For fetch, memory read and I/O read, `rd` is high from the second half of T1 through the end of the capture state. The capture state is T2 plus its waits for fetch, and T3 for data cycles. For fetch and memory read, `mreq` follows the same window.
- R8: For memory write and I/O write, `wr` is high from the second half of T2 (wait states included) through the end of T3. `mreq` (memory write) or `iorq` (I/O write) is high from the second half of T1 through the end of T3.
- R9: For I/O read and I/O write, `iorq` is high over the same window as their `rd` or `mreq`-style window. For interrupt acknowledge, `iorq` is high from the second half of T1 through the end of T2 and its waits, while `rd` stays low.
- R10: `m1` is high for fetch and interrupt acknowledge from the start of T1 through the end of T2 and its waits. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is half a bus state |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_type | input | 3 | Type of the next machine cycle (encoding in R2) |
| req_len | input | 3 | Base state count of the next machine cycle, before clamping |
| wait_req | input | 1 | Wait request from slow memory or I/O |
| m_idx | output | 3 | Index of the active machine cycle within the instruction |
| t_idx | output | 3 | Active state number; held at 2 during wait states |
| in_wait | output | 1 | High during a wait state |
| mreq | output | 1 | Memory request strobe |
| iorq | output | 1 | I/O request strobe |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| m1 | output | 1 | Opcode-fetch / acknowledge strobe |
| cyc_done | output | 1 | One-clock pulse at the end of each machine cycle |

## Verification
All outputs decode from registers, so every output reflects the state reached at the previous rising edge. A `wait_req` value presented in a sampling half shows up one clock later as `in_wait` or as `t_idx`=3. A request presented while `cyc_done` is high appears in `m_idx` and in the strobes one clock later. The bench drives inputs and samples outputs on the falling edge. It keeps its own position counter (state number, half) for the active cycle, built from that cycle's length, its automatic waits and the number of external waits the bench chose. From that position it derives the expected value of every output for the clock just ended. Outside the sampling halves and the done clock, `wait_req` and the request inputs are randomised, which shows that they are ignored there.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MRD   = 3'd1,
    CYC_MWR   = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4,
    CYC_INTA  = 3'd5
  } cyc_e;

  localparam int unsigned AUTO_W = 2;

  function automatic cyc_e decode_type(input logic [2:0] raw);
    case (raw)
      3'd0:    return CYC_FETCH;
      3'd1:    return CYC_MRD;
      3'd2:    return CYC_MWR;
      3'd3:    return CYC_IORD;
      3'd4:    return CYC_IOWR;
      3'd5:    return CYC_INTA;
      default: return CYC_MRD;
    endcase
  endfunction

  function automatic logic fetch_class(input cyc_e c);
    return (c == CYC_FETCH) || (c == CYC_INTA);
  endfunction

  function automatic logic mem_class(input cyc_e c);
    return (c == CYC_FETCH) || (c == CYC_MRD) || (c == CYC_MWR);
  endfunction

  function automatic logic io_class(input cyc_e c);
    return (c == CYC_IORD) || (c == CYC_IOWR) || (c == CYC_INTA);
  endfunction

  function automatic logic write_class(input cyc_e c);
    return (c == CYC_MWR) || (c == CYC_IOWR);
  endfunction

  function automatic logic [AUTO_W-1:0] auto_waits(input cyc_e c);
    case (c)
      CYC_IORD, CYC_IOWR: return AUTO_W'(1);
      CYC_INTA:           return AUTO_W'(2);
      default:            return AUTO_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/mcs_req_latch.sv
module mcs_req_latch
  import mcs_pkg::*;
#(
  parameter int unsigned ST_W      = 3,
  parameter int unsigned M_W       = 3,
  parameter int unsigned FETCH_MIN = 4,
  parameter int unsigned FETCH_MAX = 6,
  parameter int unsigned DATA_MIN  = 3,
  parameter int unsigned DATA_MAX  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [2:0]      req_type,
  input  logic [ST_W-1:0] req_len,
  output cyc_e            cur_type,
  output logic [ST_W-1:0] cur_len,
  output logic [M_W-1:0]  m_idx
);

  localparam logic [M_W-1:0]  M_MAX  = M_W'((1 << M_W) - 1);
  localparam logic [M_W-1:0]  M_ONE  = M_W'(1);
  localparam logic [ST_W-1:0] F_LO   = ST_W'(FETCH_MIN);
  localparam logic [ST_W-1:0] F_HI   = ST_W'(FETCH_MAX);
  localparam logic [ST_W-1:0] D_LO   = ST_W'(DATA_MIN);
  localparam logic [ST_W-1:0] D_HI   = ST_W'(DATA_MAX);

  cyc_e            type_d;
  logic [ST_W-1:0] len_d;
  logic [M_W-1:0]  m_d;
  logic [ST_W-1:0] lo_lim;
  logic [ST_W-1:0] hi_lim;

  // next-state: decode, clamp and count
  always_comb begin
    type_d = decode_type(req_type);
    lo_lim = fetch_class(type_d) ? F_LO : D_LO;
    hi_lim = fetch_class(type_d) ? F_HI : D_HI;
    if (req_len < lo_lim)      len_d = lo_lim;
    else if (req_len > hi_lim) len_d = hi_lim;
    else                       len_d = req_len;
    if (fetch_class(type_d))   m_d = M_ONE;
    else if (m_idx == M_MAX)   m_d = M_MAX;
    else                       m_d = m_idx + M_ONE;
  end

  // registers: enabled only on the closing clock of a cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_type <= CYC_FETCH;
      cur_len  <= F_LO;
      m_idx    <= M_ONE;
    end else if (load) begin
      cur_type <= type_d;
      cur_len  <= len_d;
      m_idx    <= m_d;
    end
  end

  // R6
  midx_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_idx != '0);

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_len >= D_LO) && (cur_len <= F_HI));

endmodule

// File: rtl/mcs_timer.sv
module mcs_timer
  import mcs_pkg::*;
#(
  parameter int unsigned ST_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cyc_e            cur_type,
  input  logic [ST_W-1:0] cur_len,
  input  logic            wait_req,
  output logic [ST_W-1:0] t_idx,
  output logic            second_half,
  output logic            in_wait,
  output logic            cyc_done
);

  localparam logic [ST_W-1:0] T_ONE   = ST_W'(1);
  localparam logic [ST_W-1:0] T_TWO   = ST_W'(2);
  localparam logic [ST_W-1:0] T_THREE = ST_W'(3);

  logic [ST_W-1:0]   t_q, t_d;
  logic              ph_q, ph_d;
  logic              wt_q, wt_d;
  logic [AUTO_W-1:0] aw_q, aw_d;
  logic [AUTO_W-1:0] aw_need;
  logic              last_clk;
  logic              st_en;

  assign aw_need  = auto_waits(cur_type);
  assign last_clk = ph_q && !wt_q && (t_q == cur_len);
  assign st_en    = ph_q;

  // next-state
  always_comb begin
    t_d  = t_q;
    wt_d = wt_q;
    aw_d = aw_q;
    ph_d = ~ph_q;
    if (st_en) begin
      if (last_clk) begin
        t_d  = T_ONE;
        wt_d = 1'b0;
        aw_d = '0;
      end else if (t_q == T_TWO) begin
        if (aw_q != aw_need) begin
          wt_d = 1'b1;
          aw_d = aw_q + AUTO_W'(1);
        end else if (wait_req) begin
          wt_d = 1'b1;
        end else begin
          wt_d = 1'b0;
          t_d  = T_THREE;
        end
      end else begin
        t_d = t_q + T_ONE;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q  <= T_ONE;
      ph_q <= 1'b0;
      wt_q <= 1'b0;
      aw_q <= '0;
    end else begin
      t_q  <= t_d;
      ph_q <= ph_d;
      wt_q <= wt_d;
      aw_q <= aw_d;
    end
  end

  assign t_idx       = t_q;
  assign second_half = ph_q;
  assign in_wait     = wt_q;
  assign cyc_done    = last_clk;

  // R3
  wait_at_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> (t_idx == T_TWO));

  // R5
  done_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> ((t_idx == T_ONE) && !second_half && !in_wait));

  // R4
  auto_wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aw_q <= aw_need);

endmodule

// File: rtl/mcs_strobes.sv
module mcs_strobes
  import mcs_pkg::*;
#(
  parameter int unsigned ST_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cyc_e            cur_type,
  input  logic [ST_W-1:0] t_idx,
  input  logic            second_half,
  input  logic            in_wait,
  output logic            mreq,
  output logic            iorq,
  output logic            rd,
  output logic            wr,
  output logic            m1
);

  localparam logic [ST_W-1:0] T_ONE   = ST_W'(1);
  localparam logic [ST_W-1:0] T_TWO   = ST_W'(2);
  localparam logic [ST_W-1:0] T_THREE = ST_W'(3);

  logic            t1_front;
  logic [ST_W-1:0] cap_end;
  logic            req_win;
  logic            wr_win;

  always_comb begin
    t1_front = (t_idx == T_ONE) && !second_half;
    cap_end  = fetch_class(cur_type) ? T_TWO : T_THREE;
    req_win  = !t1_front && (t_idx <= cap_end);
    wr_win   = (t_idx == T_THREE) ||
               ((t_idx == T_TWO) && (second_half || in_wait));
    mreq     = mem_class(cur_type) && req_win;
    iorq     = io_class(cur_type) && req_win;
    rd       = !write_class(cur_type) && (cur_type != CYC_INTA) && req_win;
    wr       = write_class(cur_type) && wr_win;
    m1       = fetch_class(cur_type) && (t_idx <= T_TWO);
  end

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr));

  // R9
  mreq_iorq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mreq && iorq));

  // R9
  ack_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iorq && m1) |-> !rd);

  // R8
  wr_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (mreq || iorq));

endmodule

// File: rtl/mcycle_sequencer.sv
module mcycle_sequencer
  import mcs_pkg::*;
#(
  parameter int unsigned ST_W      = 3,
  parameter int unsigned M_W       = 3,
  parameter int unsigned FETCH_MIN = 4,
  parameter int unsigned FETCH_MAX = 6,
  parameter int unsigned DATA_MIN  = 3,
  parameter int unsigned DATA_MAX  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      req_type,
  input  logic [ST_W-1:0] req_len,
  input  logic            wait_req,
  output logic [M_W-1:0]  m_idx,
  output logic [ST_W-1:0] t_idx,
  output logic            in_wait,
  output logic            mreq,
  output logic            iorq,
  output logic            rd,
  output logic            wr,
  output logic            m1,
  output logic            cyc_done
);

  cyc_e            cur_type;
  logic [ST_W-1:0] cur_len;
  logic            second_half;

  mcs_req_latch #(
    .ST_W(ST_W), .M_W(M_W),
    .FETCH_MIN(FETCH_MIN), .FETCH_MAX(FETCH_MAX),
    .DATA_MIN(DATA_MIN), .DATA_MAX(DATA_MAX)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .load(cyc_done),
    .req_type(req_type), .req_len(req_len),
    .cur_type(cur_type), .cur_len(cur_len), .m_idx(m_idx)
  );

  mcs_timer #(.ST_W(ST_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .cur_type(cur_type), .cur_len(cur_len),
    .wait_req(wait_req), .t_idx(t_idx), .second_half(second_half),
    .in_wait(in_wait), .cyc_done(cyc_done)
  );

  mcs_strobes #(.ST_W(ST_W)) u_strobes (
    .clk(clk), .rst_n(rst_n), .cur_type(cur_type), .t_idx(t_idx),
    .second_half(second_half), .in_wait(in_wait),
    .mreq(mreq), .iorq(iorq), .rd(rd), .wr(wr), .m1(m1)
  );

  // R10
  m1_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m1 |-> (!wr && !in_wait || t_idx == ST_W'(2)));

endmodule

// File: tb/mcycle_sequencer_bench.sv
module mcycle_sequencer_bench;

  logic       clk;
  logic       rst_n;
  logic [2:0] req_type;
  logic [2:0] req_len;
  logic       wait_req;
  logic [2:0] m_idx;
  logic [2:0] t_idx;
  logic       in_wait, mreq, iorq, rd, wr, m1, cyc_done;

  mcycle_sequencer u_mcycle_sequencer (
    .clk(clk), .rst_n(rst_n), .req_type(req_type), .req_len(req_len),
    .wait_req(wait_req), .m_idx(m_idx), .t_idx(t_idx), .in_wait(in_wait),
    .mreq(mreq), .iorq(iorq), .rd(rd), .wr(wr), .m1(m1), .cyc_done(cyc_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // active cycle and the one queued behind it
  int cur_t, cur_l, cur_a, cur_e;
  int nxt_t, nxt_raw, nxt_e;
  int s, ph, m_exp, pick_n;

  function automatic bit fc_of(int t); return (t == 0) || (t == 5); endfunction
  function automatic int clamp_len(int t, int raw);
    int lo = fc_of(t) ? 4 : 3;
    int hi = fc_of(t) ? 6 : 5;
    return (raw < lo) ? lo : (raw > hi) ? hi : raw;
  endfunction
  function automatic int autos_of(int t);
    return (t == 3 || t == 4) ? 1 : (t == 5) ? 2 : 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (type %0d state %0d half %0d)",
               tag, act, exp, cur_t, s, ph);
    end
  endtask

  // directed corner cases first, then random requests
  task automatic pick_next();
    int dt[16] = '{0,1,2,3,4,5,1,1,1,1,1,1,1,1,2,0};
    int dl[16] = '{6,3,5,0,7,2,4,4,4,4,4,4,4,4,3,5};
    int de[16] = '{0,2,0,1,0,3,0,0,1,0,0,0,0,0,4,2};
    if (pick_n < 16) begin
      nxt_t = dt[pick_n]; nxt_raw = dl[pick_n]; nxt_e = de[pick_n];
    end else begin
      nxt_t = $urandom_range(5, 0);
      nxt_raw = $urandom_range(7, 0);
      nxt_e = ($urandom_range(3, 0) == 0) ? $urandom_range(4, 1) : 0;
    end
    pick_n++;
  endtask

  task automatic check_clock();
    int total = cur_l + cur_a + cur_e;
    int te, we;
    bit fc, mem, io, wrt, front, win, wwin;
    string wtag;
    if (s == 0)                  begin te = 1; we = 0; end
    else if (s == 1)             begin te = 2; we = 0; end
    else if (s <= 1 + cur_a + cur_e) begin te = 2; we = 1; end
    else                         begin te = s - cur_a - cur_e + 1; we = 0; end
    fc = fc_of(cur_t); mem = (cur_t <= 2); io = (cur_t >= 3);
    wrt = (cur_t == 2) || (cur_t == 4);
    front = (te == 1) && (ph == 0);
    win = !front && (te <= (fc ? 2 : 3));
    wwin = (te == 3) || (te == 2 && (ph == 1 || we == 1));
    wtag = (we == 1 && s <= 1 + cur_a) ? "R4 in_wait" : (we == 1) ? "R3 in_wait" : "R2 in_wait";
    check("R2 t_idx", t_idx, te);
    check(wtag, in_wait, we);
    check("R5 cyc_done", cyc_done, (ph == 1 && s == total - 1));
    check("R6 m_idx", m_idx, m_exp);
    check("R7 mreq", mreq, mem && win);
    check("R7 rd", rd, !wrt && cur_t != 5 && win);
    check("R8 wr", wr, wrt && wwin);
    check("R9 iorq", iorq, io && win);
    check("R10 m1", m1, fc && te <= 2);
  endtask

  task automatic drive_inputs();
    int total = cur_l + cur_a + cur_e;
    bit sampled = (ph == 1) && (s >= 1 + cur_a) && (s <= 1 + cur_a + cur_e);
    wait_req = sampled ? (s < 1 + cur_a + cur_e) : 1'($urandom_range(1, 0));
    if (ph == 1 && s == total - 1) begin
      req_type = 3'(nxt_t); req_len = 3'(nxt_raw);
    end else begin
      req_type = 3'($urandom_range(7, 0)); req_len = 3'($urandom_range(7, 0));
    end
  endtask

  task automatic advance();
    int total = cur_l + cur_a + cur_e;
    if (ph == 0) ph = 1;
    else begin
      ph = 0;
      if (s == total - 1) begin
        s = 0;
        cur_t = nxt_t; cur_l = clamp_len(nxt_t, nxt_raw);
        cur_a = autos_of(nxt_t); cur_e = nxt_e;
        m_exp = fc_of(cur_t) ? 1 : (m_exp < 7 ? m_exp + 1 : 7);
        pick_next();
      end else s++;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int ncyc;
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_type = 3'd7; req_len = 3'd7; wait_req = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 t_idx", t_idx, 1);
    check("R1 m_idx", m_idx, 1);
    check("R1 in_wait", in_wait, 0);
    check("R1 cyc_done", cyc_done, 0);
    check("R1 m1", m1, 1);
    check("R1 strobes", {mreq, iorq, rd, wr}, 0);
    rst_n = 1'b1;
    cur_t = 0; cur_l = 4; cur_a = 0; cur_e = 0;
    s = 0; ph = 0; m_exp = 1; pick_n = 0;
    pick_next();
    ncyc = 0;
    while (ncyc < 320) begin
      if (ph == 1 && s == cur_l + cur_a + cur_e - 1) ncyc++;
      check_clock();
      drive_inputs();
      advance();
      @(negedge clk);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule